// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block is the receiving side of a two-wire serial memory for write transactions. It works one bit at a time from pre-decoded bus events: a one-cycle pulse when the serial clock rises (data is sampled), a pulse when it falls (the acknowledge line may change), and one-cycle start and stop condition pulses. A transaction carries a device byte, two byte-address bytes that together form a 13-bit address, and any number of data bytes. Every byte that the block accepts is acknowledged by pulling the data line low during the ninth clock.

Data bytes go into a 32-entry page buffer. The buffer is tagged with the upper eight address bits, and a five-bit pointer inside it advances and wraps. Nothing reaches the memory array until a stop condition arrives. The stop then starts an internal write cycle of a fixed length. During that cycle the buffered bytes are copied to an external synchronous array port, and the block ignores the bus entirely. A master can therefore poll for completion by sending a device byte and watching for an acknowledge.

Top module: `eeprom_page_target`

## Requirements
- R1: A device byte equal to `{DEV_ADDR, 1'b0}` (seven address bits MSB-first, then a 0 write bit) is acknowledged. `sda_oe` rises only at the falling clock edge that follows the eighth data bit, and it is released at the next falling edge.
- R2: A device byte with a different address, or with the write bit set to 1, is not acknowledged. The block then acknowledges no further byte and writes nothing until the next start condition.
- R3: Both byte-address bytes are acknowledged. The first byte supplies address bits 12:8 in its low five bits, and its upper three bits are ignored. The second byte supplies bits 7:0.
- R4: Every data byte is acknowledged. It is stored for address `{upper 8 bits, pointer}`, and the 5-bit pointer starts at address bits 4:0 and increments after each byte while the upper 8 bits stay fixed.
- R5: After the pointer reaches 31 it wraps to 0, so a data byte beyond the 32nd overwrites the earlier byte at the same page slot.
- R6: `arr_we` is never asserted before the stop condition. The write cycle writes exactly the page slots that received data, each with the last byte sent to it.
- R7: A stop condition after at least one data byte raises `busy` on the next clock. `busy` stays high for exactly `WCYC` cycles, and all array writes happen inside that window.
- R8: While `busy` is high, start conditions, stop conditions and bits are ignored and `sda_oe` stays low. After `busy` falls, a correct device byte is acknowledged again.
- R9: A stop condition that arrives before any data byte of the transaction does not raise `busy` and writes nothing.
- R10: A start condition before the stop condition discards the bytes buffered so far. Only bytes sent after the last start can be written.
- R11: After reset, `busy`, `sda_oe` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise | input | 1 | One-cycle pulse: serial clock rose, sample `sda_in` |
| scl_fall | input | 1 | One-cycle pulse: serial clock fell |
| start_det | input | 1 | One-cycle pulse: start condition seen |
| stop_det | input | 1 | One-cycle pulse: stop condition seen |
| sda_in | input | 1 | Serial data level |
| sda_oe | output | 1 | 1 = pull the data line low (acknowledge) |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions rely on event pulses that are one cycle wide, that never coincide with one another, and that are spaced far enough apart that a completed byte has been decided before the next falling-edge pulse. They also rely on `WCYC` being at least the page size. The bench keeps inside these limits by driving every event from tasks that space pulses three cycles apart and never overlap them. Its random transactions vary only the address, the length, the ignored address bits and the data.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADH,
    ST_ADL,
    ST_DATA,
    ST_SKIP,
    ST_BUSY
  } tgt_state_e;
endpackage

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  input  logic       ack_ok,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       sda_pull
);
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       done_d, ack_q, ack_d, pull_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ack_d  = ack_q;
    pull_d = sda_pull;
    if (hold) begin
      cnt_d  = 4'd0;
      ack_d  = 1'b0;
      pull_d = 1'b0;
    end else begin
      if (byte_done) ack_d = ack_ok;
      if (scl_rise) begin
        if (cnt_q == 4'd8) begin
          cnt_d = 4'd0;
        end else begin
          sh_d   = {sh_q[6:0], sda_in};
          cnt_d  = cnt_q + 4'd1;
          done_d = (cnt_q == 4'd7);
        end
      end
      if (scl_fall) pull_d = (cnt_q == 4'd8) && ack_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= 4'd0;
      sh_q      <= 8'd0;
      byte_done <= 1'b0;
      ack_q     <= 1'b0;
      sda_pull  <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      byte_done <= done_d;
      ack_q     <= ack_d;
      sda_pull  <= pull_d;
    end
  end

  assign byte_val = sh_q;

  // R1: the acknowledge drive starts only in the ninth clock slot
  p_ack_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (cnt_q == 4'd8));
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_W = 5,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [PAGE_W-1:0] ptr_in,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0]        slot_q [PAGE_N];
  logic [PAGE_N-1:0] vld_q, vld_d;
  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic [TAG_W-1:0]  tag_q, tag_d;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    tag_d = tag_q;
    if (clr) begin
      vld_d = '0;
    end else if (load) begin
      tag_d = tag_in;
      ptr_d = ptr_in;
    end else if (wr) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d        = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr && !load) slot_q[ptr_q] <= wdata;
  end

  assign tag       = tag_q;
  assign rd_data   = slot_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;

  // R5: the pointer steps by one and wraps inside the page
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && !load) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R4: the page tag does not move while data bytes arrive
  p_tag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && !load) |=> $stable(tag_q));
endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
  parameter int WCYC   = 1000,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              commit_act,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int CW     = $clog2(WCYC + 1);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign done       = busy && (cnt_q == CW'(WCYC - 1));
  assign commit_act = busy && (cnt_q < CW'(PAGE_N));
  assign commit_idx = cnt_q[PAGE_W-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

  // R7: busy holds until the terminal count, then drops, and never rises by itself
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/eeprom_page_target.sv
module eeprom_page_target
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter int         PAGE_W   = 5,
  parameter int         WCYC     = 1000,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int TAG_W = ADDR_W - PAGE_W;

  tgt_state_e        state_q, state_d;
  logic [HI_W-1:0]   ahi_q, ahi_d;
  logic              ack_ok, buf_load, buf_wr, buf_clr, tmr_start, tmr_done;
  logic              byte_done, sh_hold, buf_any, rd_valid, commit_act;
  logic [7:0]        byte_val, rd_data;
  logic [TAG_W-1:0]  buf_tag;
  logic [PAGE_W-1:0] commit_idx;

  assign sh_hold = start_det || stop_det || (state_q == ST_BUSY);

  ee_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .hold(sh_hold), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_in(sda_in), .ack_ok(ack_ok),
    .byte_done(byte_done), .byte_val(byte_val), .sda_pull(sda_oe)
  );

  ee_page_buf #(.PAGE_W(PAGE_W), .TAG_W(TAG_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .load(buf_load),
    .tag_in({ahi_q, byte_val[7:PAGE_W]}), .ptr_in(byte_val[PAGE_W-1:0]),
    .wr(buf_wr), .wdata(byte_val), .rd_idx(commit_idx), .tag(buf_tag),
    .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(buf_any)
  );

  ee_write_timer #(.WCYC(WCYC), .PAGE_W(PAGE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy),
    .done(tmr_done), .commit_act(commit_act), .commit_idx(commit_idx)
  );

  always_comb begin
    state_d   = state_q;
    ahi_d     = ahi_q;
    ack_ok    = 1'b0;
    buf_load  = 1'b0;
    buf_wr    = 1'b0;
    buf_clr   = 1'b0;
    tmr_start = 1'b0;
    if (state_q == ST_BUSY) begin
      if (tmr_done) begin
        state_d = ST_IDLE;
        buf_clr = 1'b1;
      end
    end else if (stop_det) begin
      if ((state_q == ST_DATA) && buf_any) begin
        state_d   = ST_BUSY;
        tmr_start = 1'b1;
      end else begin
        state_d = ST_IDLE;
        buf_clr = 1'b1;
      end
    end else if (start_det) begin
      state_d = ST_DEV;
      buf_clr = 1'b1;
    end else if (byte_done) begin
      case (state_q)
        ST_DEV: begin
          if ((byte_val[7:1] == DEV_ADDR) && !byte_val[0]) begin
            ack_ok  = 1'b1;
            state_d = ST_ADH;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_ADH: begin
          ahi_d   = byte_val[HI_W-1:0];
          ack_ok  = 1'b1;
          state_d = ST_ADL;
        end
        ST_ADL: begin
          buf_load = 1'b1;
          ack_ok   = 1'b1;
          state_d  = ST_DATA;
        end
        ST_DATA: begin
          buf_wr = 1'b1;
          ack_ok = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ahi_q   <= '0;
    end else begin
      state_q <= state_d;
      ahi_q   <= ahi_d;
    end
  end

  assign arr_we    = commit_act && rd_valid;
  assign arr_addr  = {buf_tag, commit_idx};
  assign arr_wdata = rd_data;

  // R8: no acknowledge is driven during the internal write cycle
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R6: array writes only happen inside the write cycle
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R9: a stop with an empty buffer starts no write cycle
  p_stop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !busy && !buf_any) |=> !busy);
endmodule

// File: tb/tb_eeprom_page_target.sv
module tb_eeprom_page_target;
  localparam int WCYC = 1000;

  logic        clk = 1'b0;
  logic        rst_n, scl_rise, scl_fall, start_det, stop_det, sda_in;
  logic        sda_oe, busy, arr_we;
  logic [12:0] arr_addr;
  logic [7:0]  arr_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [7:0] act_mem [int];
  logic [7:0] exp_mem [int];
  logic [7:0] pbuf [32];
  bit         pvld [32];
  int         ptag, pptr;

  always #5 clk = ~clk;

  eeprom_page_target #(.WCYC(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_in),
    .sda_oe(sda_oe), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      act_mem[int'(arr_addr)] = arr_wdata;
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic p_rise();
    scl_rise = 1'b1; tick(); scl_rise = 1'b0; tick(); tick();
  endtask

  task automatic p_fall();
    scl_fall = 1'b1; tick(); scl_fall = 1'b0; tick(); tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_in = b[i];
      p_rise();
      p_fall();
    end
    acked = sda_oe;
    p_rise();
    p_fall();
  endtask

  task automatic do_start();
    start_det = 1'b1; tick(); start_det = 1'b0; tick();
  endtask

  function automatic void clear_pending();
    for (int i = 0; i < 32; i++) pvld[i] = 1'b0;
  endfunction

  task automatic begin_write(input int addr, input logic [2:0] junk);
    logic a;
    do_start();
    clear_pending();
    send_byte(8'hA0, a);
    check(a === 1'b1, "R1 device byte ack", a, 1);
    send_byte({junk, addr[12:8]}, a);
    check(a === 1'b1, "R3 high address ack", a, 1);
    send_byte(addr[7:0], a);
    check(a === 1'b1, "R3 low address ack", a, 1);
    ptag = addr >> 5;
    pptr = addr & 31;
  endtask

  task automatic data_bytes(input int n);
    logic a;
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      check(a === 1'b1, "R4 data byte ack", a, 1);
      pbuf[pptr] = d;
      pvld[pptr] = 1'b1;
      pptr = (pptr + 1) % 32;
    end
  endtask

  task automatic stop_commit(input int wr_before);
    check(wr_cnt == wr_before, "R6 no array write before stop", wr_cnt, wr_before);
    stop_det = 1'b1; tick(); stop_det = 1'b0;
    for (int i = 0; i < 32; i++) if (pvld[i]) exp_mem[ptag * 32 + i] = pbuf[i];
    clear_pending();
    check(busy === 1'b1, "R7 busy after stop", busy, 1);
  endtask

  task automatic busy_len();
    int n = 0;
    while (busy === 1'b1 && n < 5 * WCYC) begin n++; tick(); end
    check(n == WCYC, "R7 busy length", n, WCYC);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    foreach (exp_mem[k]) if (!act_mem.exists(k) || act_mem[k] !== exp_mem[k]) bad++;
    if (act_mem.num() != exp_mem.num()) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic page_write(input int addr, input int n, input logic [2:0] junk, input string req);
    int w0;
    begin_write(addr, junk);
    w0 = wr_cnt;
    data_bytes(n);
    stop_commit(w0);
    busy_len();
    cmp_mem(req);
  endtask

  task automatic quiet_stop(input string req);
    int w0 = wr_cnt;
    stop_det = 1'b1; tick(); stop_det = 1'b0; tick(); tick();
    check(busy === 1'b0, req, busy, 0);
    check(wr_cnt == w0, req, wr_cnt, w0);
  endtask

  initial begin
    logic a;
    int w0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; scl_rise = 1'b0; scl_fall = 1'b0;
    start_det = 1'b0; stop_det = 1'b0; sda_in = 1'b1;
    clear_pending();
    repeat (4) tick();
    check(busy === 1'b0, "R11 reset busy", busy, 0);
    check(sda_oe === 1'b0, "R11 reset sda_oe", sda_oe, 0);
    check(arr_we === 1'b0, "R11 reset arr_we", arr_we, 0);
    rst_n = 1'b1;
    tick();

    page_write(13'h0123, 3, 3'b000, "R4 short page write");
    page_write(13'h0A5E, 35, 3'b101, "R5 wrap overwrite and R3 ignored bits");
    page_write(13'h0040, 32, 3'b111, "R4 full page");

    begin_write(13'h0300, 3'b000);
    quiet_stop("R9 stop before data");

    do_start();
    send_byte(8'hA2, a);
    check(a === 1'b0, "R2 wrong device address nack", a, 0);
    send_byte(8'h00, a);
    check(a === 1'b0, "R2 later byte nack", a, 0);
    quiet_stop("R2 no write after nack");

    do_start();
    send_byte(8'hA1, a);
    check(a === 1'b0, "R2 read bit nack", a, 0);
    quiet_stop("R2 no write after read bit");

    begin_write(13'h0500, 3'b000);
    data_bytes(2);
    begin_write(13'h0620, 3'b000);
    w0 = wr_cnt;
    data_bytes(1);
    stop_commit(w0);
    busy_len();
    check(!act_mem.exists(13'h0500) && !act_mem.exists(13'h0501),
          "R10 discarded bytes absent", act_mem.num(), exp_mem.num());
    cmp_mem("R10 only post-restart bytes");

    begin_write(13'h0777, 3'b010);
    w0 = wr_cnt;
    data_bytes(2);
    stop_commit(w0);
    do_start();
    send_byte(8'hA0, a);
    check(a === 1'b0, "R8 no ack while busy", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h55, a);
    stop_det = 1'b1; tick(); stop_det = 1'b0;
    while (busy === 1'b1) tick();
    tick();
    cmp_mem("R8 bus ignored while busy");
    do_start();
    send_byte(8'hA0, a);
    check(a === 1'b1, "R8 ack after busy ends", a, 1);
    quiet_stop("R9 poll then stop");

    for (int t = 0; t < 10; t++) begin
      page_write(int'($urandom % 8192), 1 + int'($urandom % 40),
                 3'($urandom), "R4 R5 random page write");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7: run hung, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule